// File: doc/BRIEF.md
# Shift-Reuse Convolution Tile Engine

This block computes one tile of a convolution output feature map on a Px by Py mesh of processing elements (default 4x4). Each element owns a single output neuron and walks the whole kernel window for it, one kernel position per cycle. The kernel weight for the current position is broadcast to every element at once. Input neurons are mostly reused: they slide one place toward column 0 between kernel columns and one place toward row 0 between kernel rows. Only the edge column or the edge row is fed from outside. A second mode replaces multiply-accumulate with a running maximum for max pooling.

A start pulse latches the kernel width and height (1 to 7) and the mode. The engine first loads the initial tile row by row through the row edge port. It then runs Kx*Ky accumulate steps. Finally it raises done for one cycle with all Px*Py saturated results on a parallel bus. The engine publishes which image row, image column and kernel position it needs in each cycle, and the surrounding buffer answers on the same cycle.

Top module: `shiftconv_array`

## Requirements
- R1: After reset, busy and done are low and the result bus is all zeros.
- R2: A start pulse seen while busy is low latches k_cols, k_rows and pool_mode. A size of 0 behaves as 1. Later changes on these inputs, and start pulses while busy is high, do not change the run or its results.
- R3: For Py cycles after start, the engine loads the tile through the row edge port. fetch_row counts 0..Py-1, and lane c of row_in (bits 16c+15:16c) must carry image[fetch_row][c].
- R4: The kernel scan visits kernel column (kx) positions inside each kernel row (ky). step_kx and step_ky report the position, and weight must carry w[step_ky][step_kx] in that cycle.
- R5: Between kernel columns, operands shift toward column 0. Lane r of col_in must carry image[r+step_ky][fetch_col], where fetch_col = Px+step_kx.
- R6: Between kernel rows, the row-start operands shift toward row 0. The row edge is then loaded from image[Py+step_ky] via fetch_row.
- R7: In convolution mode (pool_mode=0, Q8.8 operands), output (r,c) equals the saturated sum over the window of (image[r+i][c+j]*w[i][j]) arithmetically shifted right by 8.
- R8: Results beyond the 16-bit range clamp to 32767 or -32768.
- R9: In pooling mode (pool_mode=1), output (r,c) is the maximum signed image value in its Kx by Ky window, and the weights are ignored.
- R10: done is high for exactly one cycle: the cycle beginning Py+Kx*Ky clock edges after the edge that accepted start.
- R11: Output (r,c) sits on result bits 16(r*Px+c)+15 down to 16(r*Px+c), and the bus reads zero whenever done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile when idle |
| pool_mode | input | 1 | 0 convolution, 1 max pooling |
| k_cols | input | 3 | Kernel width Kx (0 treated as 1) |
| k_rows | input | 3 | Kernel height Ky (0 treated as 1) |
| weight | input | 16 | Broadcast Q8.8 kernel weight |
| row_in | input | PX*16 | Edge row of input neurons |
| col_in | input | PY*16 | Edge column of input neurons |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle result strobe |
| step_kx | output | 3 | Current kernel column |
| step_ky | output | 3 | Current kernel row |
| fetch_row | output | IW | Image row wanted on row_in |
| fetch_col | output | IW | Image column wanted on col_in |
| result | output | PX*PY*16 | Saturated outputs, valid with done |

## Verification
A misrouted neighbour link or a wrong shift cycle corrupts a whole diagonal of outputs. It shows on the result bus at the single done cycle of that same tile, and a sweep over every kernel shape separates horizontal faults from vertical ones. A sequencer counting fault moves done off its Py+Kx*Ky slot or misaligns step_kx and step_ky with the weight. Either way the next tile shows it within one run. Accumulator clear or saturation faults show up as wrong values in large-operand or pooling runs.

// File: rtl/scpe_pkg.sv
package scpe_pkg;
  parameter int SC_DW   = 16;
  parameter int SC_AW   = 32;
  parameter int SC_FRAC = 8;
  parameter int SC_KW   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ACC  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  localparam logic signed [SC_AW-1:0] SAT_HI = SC_AW'((64'sd1 <<< (SC_DW-1)) - 1);
  localparam logic signed [SC_AW-1:0] SAT_LO = -SC_AW'(64'sd1 <<< (SC_DW-1));

  function automatic logic signed [SC_DW-1:0] sat_q(input logic signed [SC_AW-1:0] a);
    if (a > SAT_HI)      sat_q = SC_DW'(SAT_HI);
    else if (a < SAT_LO) sat_q = SC_DW'(SAT_LO);
    else                 sat_q = SC_DW'(a);
  endfunction
endpackage

// File: rtl/scpe_cell.sv
module scpe_cell
  import scpe_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    pool,
  input  logic                    acc_en,
  input  logic                    hsh,
  input  logic                    vsh,
  input  logic signed [SC_DW-1:0] h_in,
  input  logic signed [SC_DW-1:0] v_in,
  input  logic signed [SC_DW-1:0] w_in,
  output logic signed [SC_DW-1:0] cur_o,
  output logic signed [SC_DW-1:0] base_o,
  output logic signed [SC_DW-1:0] res_o
);
  logic signed [SC_DW-1:0]   cur_q, cur_d, base_q, base_d;
  logic signed [SC_AW-1:0]   acc_q, acc_d, term, cur_x;
  logic signed [2*SC_DW-1:0] prod;
  logic                      opnd_en, acc_upd;

  always_comb begin
    prod    = cur_q * w_in;
    term    = SC_AW'(prod >>> SC_FRAC);
    cur_x   = SC_AW'(cur_q);
    opnd_en = hsh | vsh;
    acc_upd = clr | acc_en;
    cur_d   = vsh ? v_in : h_in;
    base_d  = v_in;
    if (clr)       acc_d = pool ? SAT_LO : '0;
    else if (pool) acc_d = (cur_x > acc_q) ? cur_x : acc_q;
    else           acc_d = acc_q + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
      acc_q  <= '0;
    end else begin
      if (opnd_en) cur_q  <= cur_d;
      if (vsh)     base_q <= base_d;
      if (acc_upd) acc_q  <= acc_d;
    end
  end

  assign cur_o  = cur_q;
  assign base_o = base_q;
  assign res_o  = sat_q(acc_q);
endmodule

// File: rtl/scpe_seq.sv
module scpe_seq
  import scpe_pkg::*;
#(
  parameter int PY = 4,
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [SC_KW-1:0] kw,
  input  logic [SC_KW-1:0] kh,
  output logic             clr,
  output logic             pool_q,
  output logic             acc_en,
  output logic             hsh,
  output logic             vsh,
  output logic             busy,
  output logic             done,
  output logic [SC_KW-1:0] kx,
  output logic [SC_KW-1:0] ky,
  output logic [IW-1:0]    fetch_row
);
  seq_state_t       st_q, st_d;
  logic [SC_KW-1:0] kxs_q, kxs_d, kys_q, kys_d, kx_q, kx_d, ky_q, ky_d;
  logic [IW-1:0]    pc_q, pc_d;
  logic             pool_d, last_x, last_y;

  always_comb begin
    st_d   = st_q;
    kxs_d  = kxs_q;
    kys_d  = kys_q;
    kx_d   = kx_q;
    ky_d   = ky_q;
    pc_d   = pc_q;
    pool_d = pool_q;
    last_x = (kx_q == kxs_q - 1'b1);
    last_y = (ky_q == kys_q - 1'b1);
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_LOAD;
        kxs_d  = (kw == '0) ? SC_KW'(1) : kw;
        kys_d  = (kh == '0) ? SC_KW'(1) : kh;
        pool_d = mode;
        kx_d   = '0;
        ky_d   = '0;
        pc_d   = '0;
      end
      ST_LOAD: begin
        pc_d = pc_q + 1'b1;
        if (pc_q == IW'(PY - 1)) st_d = ST_ACC;
      end
      ST_ACC: begin
        if (!last_x) kx_d = kx_q + 1'b1;
        else begin
          kx_d = '0;
          if (!last_y) ky_d = ky_q + 1'b1;
          else         st_d = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kxs_q  <= SC_KW'(1);
      kys_q  <= SC_KW'(1);
      kx_q   <= '0;
      ky_q   <= '0;
      pc_q   <= '0;
      pool_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kxs_q  <= kxs_d;
      kys_q  <= kys_d;
      kx_q   <= kx_d;
      ky_q   <= ky_d;
      pc_q   <= pc_d;
      pool_q <= pool_d;
    end
  end

  always_comb begin
    clr       = (st_q == ST_IDLE) && start;
    acc_en    = (st_q == ST_ACC);
    hsh       = acc_en && !last_x;
    vsh       = (st_q == ST_LOAD) || (acc_en && last_x && !last_y);
    busy      = (st_q != ST_IDLE);
    done      = (st_q == ST_DONE);
    kx        = kx_q;
    ky        = ky_q;
    fetch_row = (st_q == ST_LOAD) ? pc_q : IW'(PY) + IW'(ky_q);
  end
endmodule

// File: rtl/shiftconv_array.sv
module shiftconv_array
  import scpe_pkg::*;
#(
  parameter int PX = 4,
  parameter int PY = 4,
  localparam int PMAX = (PX > PY) ? PX : PY,
  localparam int IW = $clog2(PMAX + 8)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      pool_mode,
  input  logic [SC_KW-1:0]          k_cols,
  input  logic [SC_KW-1:0]          k_rows,
  input  logic [SC_DW-1:0]          weight,
  input  logic [PX*SC_DW-1:0]       row_in,
  input  logic [PY*SC_DW-1:0]       col_in,
  output logic                      busy,
  output logic                      done,
  output logic [SC_KW-1:0]          step_kx,
  output logic [SC_KW-1:0]          step_ky,
  output logic [IW-1:0]             fetch_row,
  output logic [IW-1:0]             fetch_col,
  output logic [PX*PY*SC_DW-1:0]    result
);
  logic clr, pool_q, acc_en, hsh, vsh, cell_pool;
  logic signed [SC_DW-1:0] cur_w  [PY][PX];
  logic signed [SC_DW-1:0] base_w [PY][PX];
  logic signed [SC_DW-1:0] res_w  [PY][PX];

  scpe_seq #(.PY(PY), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(pool_mode),
    .kw(k_cols), .kh(k_rows), .clr(clr), .pool_q(pool_q),
    .acc_en(acc_en), .hsh(hsh), .vsh(vsh), .busy(busy), .done(done),
    .kx(step_kx), .ky(step_ky), .fetch_row(fetch_row)
  );

  assign fetch_col = IW'(PX) + IW'(step_kx);
  assign cell_pool = clr ? pool_mode : pool_q;

  for (genvar r = 0; r < PY; r++) begin : g_row
    for (genvar c = 0; c < PX; c++) begin : g_col
      logic signed [SC_DW-1:0] h_src, v_src;
      if (c == PX - 1) begin : g_hedge
        assign h_src = col_in[r*SC_DW +: SC_DW];
      end else begin : g_hnbr
        assign h_src = cur_w[r][c+1];
      end
      if (r == PY - 1) begin : g_vedge
        assign v_src = row_in[c*SC_DW +: SC_DW];
      end else begin : g_vnbr
        assign v_src = base_w[r+1][c];
      end
      scpe_cell u_cell (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pool(cell_pool),
        .acc_en(acc_en), .hsh(hsh), .vsh(vsh),
        .h_in(h_src), .v_in(v_src), .w_in(weight),
        .cur_o(cur_w[r][c]), .base_o(base_w[r][c]), .res_o(res_w[r][c])
      );
      assign result[(r*PX+c)*SC_DW +: SC_DW] = done ? res_w[r][c] : '0;
    end
  end
endmodule

// File: rtl/scpe_chk.sv
module scpe_chk
  import scpe_pkg::*;
#(
  parameter int PX = 4,
  parameter int PY = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [SC_KW-1:0]       k_cols,
  input logic [SC_KW-1:0]       k_rows,
  input logic [SC_KW-1:0]       step_kx,
  input logic [SC_KW-1:0]       step_ky,
  input logic [PX*PY*SC_DW-1:0] result
);
  logic             run_q;
  logic [7:0]       cnt_q;
  logic [SC_KW-1:0] kxs_q, kys_q;
  logic [7:0]       tgt;

  assign tgt = 8'(PY) + 8'(kxs_q) * 8'(kys_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      kxs_q <= SC_KW'(1);
      kys_q <= SC_KW'(1);
    end else if (start && !busy) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      kxs_q <= (k_cols == '0) ? SC_KW'(1) : k_cols;
      kys_q <= (k_rows == '0) ? SC_KW'(1) : k_rows;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (done) run_q <= 1'b0;
    end
  end

  // R10
  done_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q && cnt_q == tgt));
  // R10
  done_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == tgt) |-> done);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (result == '0));
  // R4
  kx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && busy) |-> (step_kx < kxs_q && step_ky < kys_q));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind shiftconv_array scpe_chk #(.PX(PX), .PY(PY)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .k_cols(k_cols), .k_rows(k_rows), .step_kx(step_kx), .step_ky(step_ky),
  .result(result)
);

// File: tb/shiftconv_array_tb.sv
module shiftconv_array_tb;
  localparam int PX = 4;
  localparam int PY = 4;
  localparam int IW = 4;

  logic clk, rst_n, start, pool_mode, busy, done;
  logic [2:0] k_cols, k_rows, step_kx, step_ky;
  logic [15:0] weight;
  logic [PX*16-1:0] row_in;
  logic [PY*16-1:0] col_in;
  logic [IW-1:0] fetch_row, fetch_col;
  logic [PX*PY*16-1:0] result;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic signed [15:0] img [16][16];
  logic signed [15:0] wt [8][8];

  shiftconv_array #(.PX(PX), .PY(PY)) u_dut (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat16(input longint a);
    if (a > 32767) return 32767;
    if (a < -32768) return -32768;
    return a;
  endfunction

  function automatic longint model(input int r, input int c, input int kx, input int ky, input bit pool);
    longint s;
    s = pool ? -32768 : 0;
    for (int i = 0; i < ky; i++)
      for (int j = 0; j < kx; j++) begin
        if (pool) begin
          if (img[r+i][c+j] > s) s = img[r+i][c+j];
        end else
          s += (longint'(img[r+i][c+j]) * longint'(wt[i][j])) >>> 8;
      end
    return sat16(s);
  endfunction

  task automatic fill(input int span);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        img[i][j] = (span >= 65536) ? 16'($urandom) : 16'($signed($urandom_range(span - 1)) - span / 2);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        wt[i][j] = (span >= 65536) ? 16'($urandom) : 16'($signed($urandom_range(span - 1)) - span / 2);
  endtask

  // R3 R4 R5 R6: answer the engine's requests from the image model
  task automatic feed();
    weight = wt[step_ky][step_kx];
    for (int c = 0; c < PX; c++) row_in[c*16 +: 16] = img[fetch_row][c];
    for (int r = 0; r < PY; r++) col_in[r*16 +: 16] = img[r + int'(step_ky)][fetch_col];
  endtask

  task automatic run_case(input int kc, input int kr, input bit pool, input bit glitch, input string req);
    int ex, ey, j;
    ex = (kc == 0) ? 1 : kc;
    ey = (kr == 0) ? 1 : kr;
    @(negedge clk);
    start = 1; pool_mode = pool; k_cols = 3'(kc); k_rows = 3'(kr);
    feed();
    @(negedge clk);
    start = 0;
    // R2: scramble configuration inputs once the run is latched
    k_cols = 3'($urandom); k_rows = 3'($urandom); pool_mode = !pool;
    j = 0;
    while (!done && j < 200) begin
      feed();
      start = (glitch && (j == 2 || j == PY + 1)) ? 1'b1 : 1'b0;
      @(negedge clk);
      j++;
    end
    start = 0;
    // R10
    chk({req, " R10 done slot"}, j, PY + ex * ey);
    for (int r = 0; r < PY; r++)
      for (int c = 0; c < PX; c++)
        chk(req, longint'($signed(result[(r*PX+c)*16 +: 16])), model(r, c, ex, ey, pool));
    @(negedge clk);
    // R10 R11
    chk("R10 single-cycle done", longint'(done), 0);
    chk("R11 bus zero after done", longint'(result == '0), 1);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; pool_mode = 0; k_cols = 1; k_rows = 1;
    weight = 0; row_in = '0; col_in = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy after reset", longint'(busy), 0);
    chk("R1 done after reset", longint'(done), 0);
    chk("R1 result after reset", longint'(result == '0), 1);
    rst_n = 1;
    @(negedge clk);
    // R4 R5 R6 R7 R10 R11: every kernel shape, small operands
    for (int ky = 1; ky <= 7; ky++)
      for (int kx = 1; kx <= 7; kx++) begin
        fill(1024);
        run_case(kx, ky, 0, 0, "R7 conv sweep");
      end
    // R8: full-range operands drive clamping
    for (int t = 0; t < 6; t++) begin
      fill(65536);
      run_case(7, 7, 0, 0, "R8 saturation");
      fill(65536);
      run_case(2 + t % 5, 3, 0, 0, "R8 saturation mixed");
    end
    // R9: pooling over several shapes, weights irrelevant
    for (int t = 1; t <= 7; t++) begin
      fill(65536);
      run_case(t, 8 - t, 1, 0, "R9 max pool");
    end
    fill(200);
    run_case(1, 1, 1, 0, "R9 max pool 1x1");
    // R2: zero size behaves as one, stray start pulses ignored
    fill(1024);
    run_case(0, 0, 0, 0, "R2 zero size");
    fill(1024);
    run_case(0, 5, 0, 0, "R2 zero width");
    for (int t = 0; t < 4; t++) begin
      fill(1024);
      run_case(3 + t, 2, t % 2, 1, "R2 start while busy");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule